// File: doc/BRIEF.md
# Multi-Bank SDRAM Command Monitor

This block watches the command pins of a four-bank SDRAM and judges every command against the state of the bank it targets and the state of the device as a whole. On each rising clock edge it samples chip-select, the row strobe, the column strobe, write-enable, the bank select and the address. It decodes them into a command code and checks them against the minimum-spacing rules. The result appears on the outputs one cycle later: a command code, a one-cycle illegal flag, a reason code and the number of the offending bank.

Internally every bank runs a small state machine: idle, opening, open, read burst, write burst, precharging, or locked by auto-precharge. Each bank has its own countdown and its own row-active timer. Device-wide counters cover refresh busy time, the settle time after a mode load, and the spacing between activates. A legal mode load with bank select 0 sets the burst length, and the burst length then sizes the burst windows and the auto-precharge windows. An illegal command leaves all tracked state unchanged. The monitor is meant to sit beside a memory controller in simulation, or on silicon as an on-chip protocol watchdog.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Command codes, with chip-select and the strobes active low: chip-select high gives 0 (deselect). With chip-select low, {ras,cas,we} = 111 gives 1 (no-op), 110 gives 2 (burst stop), 011 gives 5 (activate), 001 gives 7 (refresh) and 000 gives 8 (mode load). 101 gives 3 (read), or 9 when A8 is high (read with auto-precharge). 100 gives 4 (write), or 10 with A8 high. 010 gives 6 (single-bank precharge), or 11 with A8 high (precharge all).
- R2: A read or write to a bank that is idle or still precharging is illegal with reason 1.
- R3: An activate to a bank that is opening or open is illegal with reason 2.
- R4: These commands are illegal with reason 4: a read or write before TRCD cycles after that bank's activate; a precharge of an open bank before TRAS cycles; an activate less than TRRD cycles after the last accepted activate; an activate before TRP cycles after a precharge.
- R5: After a read with auto-precharge at cycle n, every command to that bank before n + BL/2 + TRP is illegal with reason 5. After a write with auto-precharge, the limit is n + BL/2 + 1 + TDPL + TRP. When the window ends, the bank is idle.
- R6: Refresh and mode load are illegal with reason 3 unless every bank is idle. The reported bank is the lowest-numbered bank that is not idle.
- R7: Any command other than deselect or no-op is illegal with reason 6 for TRFC−1 cycles after an accepted refresh and for TMRD−1 cycles after an accepted mode load.
- R8: A burst stop with no read burst in progress is illegal with reason 7. A write issued while any read burst is in progress is illegal with reason 7. A read burst occupies the BL/2 cycles that follow the read.
- R9: A precharge with A8 low acts on the bank selected by BA, and on an idle bank it is a legal no-op. With A8 high it acts on all banks, ignores BA, and reports the lowest-numbered bank that breaks a rule.
- R10: A legal mode load with BA = 0 sets the burst length from A[2:0]: 1 gives 2, 2 gives 4, 3 gives 8. Other values leave the burst length unchanged.
- R11: Outputs are registered one cycle after the command edge. The flag lasts one cycle. The bank output is 0 for legal commands. An illegal command changes no bank or device state.
- R12: Reset clears all outputs to 0, makes every bank idle, clears all counters and sets the burst length to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Address; A8 selects auto-precharge or all-bank precharge, A[2:0] carries the burst length on a mode load |
| cmd_code | output | 4 | Decoded command code (R1) |
| illegal | output | 1 | One-cycle violation flag |
| reason | output | 3 | Violation class, 0 when legal |
| bad_bank | output | 2 | Bank blamed for the violation |

## Verification
A single command stream walks two banks through overlapping lifetimes. Each spacing rule is probed one cycle before its limit and again exactly at its limit, which separates an off-by-one in any counter from a correct boundary. Auto-precharge windows are probed for reads and for writes, after which a read shows that the row has closed. The burst length is reprogrammed to eight and then to two: burst stops that are legal only inside the longer window, and illegal just after the shorter one, show that the mode field really sizes the bursts. An illegal activate followed by a legal one to the same bank, and a read after a reset in the middle of a run, show that rejected commands and reset leave no stale state.

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor #(
  parameter int TRCD = 4,
  parameter int TRP  = 4,
  parameter int TRAS = 7,
  parameter int TRFC = 13,
  parameter int TDPL = 2,
  parameter int TRRD = 2,
  parameter int TMRD = 2,
  parameter int CW   = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        ras_n,
  input  logic        cas_n,
  input  logic        we_n,
  input  logic [1:0]  ba,
  input  logic [11:0] addr,
  output logic [3:0]  cmd_code,
  output logic        illegal,
  output logic [2:0]  reason,
  output logic [1:0]  bad_bank
);
  localparam int NB = 4;

  localparam logic [3:0] C_DSEL = 4'd0, C_NOP = 4'd1, C_BST = 4'd2, C_RD = 4'd3,
                         C_WR = 4'd4, C_ACT = 4'd5, C_PRE = 4'd6, C_REF = 4'd7,
                         C_MRS = 4'd8, C_RDA = 4'd9, C_WRA = 4'd10, C_PALL = 4'd11;

  localparam logic [2:0] E_NONE = 3'd0, E_CLOSED = 3'd1, E_OPEN = 3'd2, E_NIDLE = 3'd3,
                         E_SPACE = 3'd4, E_APLK = 3'd5, E_BUSY = 3'd6, E_TURN = 3'd7;

  typedef enum logic [2:0] {S_IDLE, S_ACTG, S_ACT, S_RD, S_WR, S_PRE, S_APC} bst_t;

  bst_t          st  [NB];
  bst_t          eff [NB];
  logic [CW-1:0] cnt [NB];
  logic [CW-1:0] ras [NB];
  logic [CW-1:0] rfc, mrd, rrd, bhalf;

  logic [3:0] code;
  logic       bad;
  logic [2:0] why;
  logic [1:0] who;
  logic       any_rd, all_idle, active;
  logic       unused_addr;

  assign unused_addr = ^{addr[11:9], addr[7:3]};
  assign active = (code != C_DSEL) && (code != C_NOP);

  always_comb begin
    if (cs_n) code = C_DSEL;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  code = C_NOP;
        3'b110:  code = C_BST;
        3'b101:  code = addr[8] ? C_RDA : C_RD;
        3'b100:  code = addr[8] ? C_WRA : C_WR;
        3'b011:  code = C_ACT;
        3'b010:  code = addr[8] ? C_PALL : C_PRE;
        3'b001:  code = C_REF;
        default: code = C_MRS;
      endcase
    end
  end

  always_comb begin
    any_rd   = 1'b0;
    all_idle = 1'b1;
    for (int b = 0; b < NB; b++) begin
      case (st[b])
        S_ACTG:      eff[b] = (cnt[b] == '0) ? S_ACT : S_ACTG;
        S_RD, S_WR:  eff[b] = (cnt[b] == '0) ? S_ACT : st[b];
        S_PRE, S_APC: eff[b] = (cnt[b] == '0) ? S_IDLE : st[b];
        default:     eff[b] = st[b];
      endcase
      if (eff[b] == S_RD) any_rd = 1'b1;
      if (eff[b] != S_IDLE) all_idle = 1'b0;
    end
  end

  always_comb begin
    bad = 1'b0;
    why = E_NONE;
    who = ba;
    if (active) begin
      if (rfc != '0 || mrd != '0) begin
        bad = 1'b1; why = E_BUSY;
      end else begin
        case (code)
          C_BST: if (!any_rd) begin bad = 1'b1; why = E_TURN; end
          C_RD, C_RDA, C_WR, C_WRA: begin
            if (eff[ba] == S_APC) begin bad = 1'b1; why = E_APLK; end
            else if (eff[ba] == S_IDLE || eff[ba] == S_PRE) begin bad = 1'b1; why = E_CLOSED; end
            else if (eff[ba] == S_ACTG) begin bad = 1'b1; why = E_SPACE; end
            else if ((code == C_WR || code == C_WRA) && any_rd) begin bad = 1'b1; why = E_TURN; end
          end
          C_ACT: begin
            if (eff[ba] == S_APC) begin bad = 1'b1; why = E_APLK; end
            else if (eff[ba] == S_PRE) begin bad = 1'b1; why = E_SPACE; end
            else if (eff[ba] != S_IDLE) begin bad = 1'b1; why = E_OPEN; end
            else if (rrd != '0) begin bad = 1'b1; why = E_SPACE; end
          end
          C_PRE: begin
            if (eff[ba] == S_APC) begin bad = 1'b1; why = E_APLK; end
            else if (eff[ba] != S_IDLE && eff[ba] != S_PRE && ras[ba] != '0) begin
              bad = 1'b1; why = E_SPACE;
            end
          end
          C_PALL: begin
            for (int b = NB - 1; b >= 0; b--) begin
              if (eff[b] == S_APC) begin bad = 1'b1; why = E_APLK; who = 2'(b); end
              else if (eff[b] != S_IDLE && eff[b] != S_PRE && ras[b] != '0) begin
                bad = 1'b1; why = E_SPACE; who = 2'(b);
              end
            end
          end
          C_REF, C_MRS: begin
            for (int b = NB - 1; b >= 0; b--) begin
              if (eff[b] != S_IDLE) begin bad = 1'b1; why = E_NIDLE; who = 2'(b); end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        st[b]  <= S_IDLE;
        cnt[b] <= '0;
        ras[b] <= '0;
      end
      rfc      <= '0;
      mrd      <= '0;
      rrd      <= '0;
      bhalf    <= CW'(2);
      cmd_code <= C_DSEL;
      illegal  <= 1'b0;
      reason   <= E_NONE;
      bad_bank <= 2'd0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        st[b]  <= eff[b];
        cnt[b] <= (cnt[b] == '0) ? '0 : cnt[b] - 1'b1;
        ras[b] <= (ras[b] == '0) ? '0 : ras[b] - 1'b1;
      end
      rfc <= (rfc == '0) ? '0 : rfc - 1'b1;
      mrd <= (mrd == '0) ? '0 : mrd - 1'b1;
      rrd <= (rrd == '0) ? '0 : rrd - 1'b1;

      cmd_code <= code;
      illegal  <= bad;
      reason   <= why;
      bad_bank <= bad ? who : 2'd0;

      if (!bad) begin
        case (code)
          C_ACT: begin
            st[ba]  <= S_ACTG;
            cnt[ba] <= CW'(TRCD - 1);
            ras[ba] <= CW'(TRAS - 1);
            rrd     <= CW'(TRRD - 1);
          end
          C_RD:  begin st[ba] <= S_RD;  cnt[ba] <= bhalf; end
          C_WR:  begin st[ba] <= S_WR;  cnt[ba] <= bhalf; end
          C_RDA: begin st[ba] <= S_APC; cnt[ba] <= bhalf + CW'(TRP - 1); end
          C_WRA: begin st[ba] <= S_APC; cnt[ba] <= bhalf + CW'(TDPL + TRP); end
          C_PRE:
            if (eff[ba] != S_IDLE && eff[ba] != S_PRE) begin
              st[ba] <= S_PRE; cnt[ba] <= CW'(TRP - 1);
            end
          C_PALL:
            for (int b = 0; b < NB; b++)
              if (eff[b] != S_IDLE && eff[b] != S_PRE) begin
                st[b] <= S_PRE; cnt[b] <= CW'(TRP - 1);
              end
          C_BST:
            for (int b = 0; b < NB; b++)
              if (eff[b] == S_RD) begin
                st[b] <= S_ACT; cnt[b] <= '0;
              end
          C_REF: rfc <= CW'(TRFC - 1);
          C_MRS: begin
            mrd <= CW'(TMRD - 1);
            if (ba == 2'd0) begin
              case (addr[2:0])
                3'd1: bhalf <= CW'(1);
                3'd2: bhalf <= CW'(2);
                3'd3: bhalf <= CW'(4);
                default: ;
              endcase
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (cmd_code == C_DSEL && !illegal)); // R1

  AST_READ_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (code == C_RD && rfc == '0 && mrd == '0 && eff[ba] == S_IDLE) |=> (illegal && reason == E_CLOSED)); // R2

  AST_REF_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (code == C_REF && rfc == '0 && mrd == '0 && !all_idle) |=> (illegal && reason == E_NIDLE)); // R6

  AST_REFRESH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rfc != '0) |=> (illegal && reason == E_BUSY)); // R7

  AST_MODE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mrd != '0) |=> illegal); // R7

  for (genvar gb = 0; gb < NB; gb++) begin : g_bank
    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (code == C_ACT && ba == 2'(gb) && !bad) |=> (st[gb] == S_ACTG || TRCD == 1)); // R3
  end
endmodule

// File: tb/tb_sdram_cmd_monitor.sv
module tb_sdram_cmd_monitor;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [11:0] addr;
  logic [3:0]  cmd_code;
  logic        illegal;
  logic [2:0]  reason;
  logic [1:0]  bad_bank;

  int checks = 0;
  int fails  = 0;

  sdram_cmd_monitor dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .cmd_code(cmd_code), .illegal(illegal), .reason(reason),
    .bad_bank(bad_bank)
  );

  // {cycle, stim kind, ba, addr, exp code, exp flag, exp reason, exp bank, req}
  localparam int NT = 40;
  localparam logic [39:0] TBL [NT] = '{
    {8'd1,  4'd3, 2'd0, 12'h000, 4'd3,  1'b1, 3'd1, 2'd0, 4'd2},   // R2 read to idle bank
    {8'd2,  4'd2, 2'd0, 12'h000, 4'd2,  1'b1, 3'd7, 2'd0, 4'd8},   // R8 stop without read
    {8'd3,  4'd5, 2'd0, 12'h000, 4'd5,  1'b0, 3'd0, 2'd0, 4'd1},   // R1 activate
    {8'd4,  4'd5, 2'd1, 12'h000, 4'd5,  1'b1, 3'd4, 2'd1, 4'd4},   // R4 activate spacing
    {8'd5,  4'd5, 2'd1, 12'h000, 4'd5,  1'b0, 3'd0, 2'd0, 4'd11},  // R11 rejected act left no trace
    {8'd6,  4'd3, 2'd0, 12'h000, 4'd3,  1'b1, 3'd4, 2'd0, 4'd4},   // R4 read before row delay
    {8'd7,  4'd3, 2'd0, 12'h000, 4'd3,  1'b0, 3'd0, 2'd0, 4'd1},   // R1 read
    {8'd8,  4'd2, 2'd0, 12'h000, 4'd2,  1'b0, 3'd0, 2'd0, 4'd8},   // R8 stop during read
    {8'd9,  4'd4, 2'd1, 12'h000, 4'd4,  1'b0, 3'd0, 2'd0, 4'd1},   // R1 write
    {8'd10, 4'd6, 2'd0, 12'h000, 4'd6,  1'b0, 3'd0, 2'd0, 4'd4},   // R4 precharge at row-active limit
    {8'd11, 4'd5, 2'd0, 12'h000, 4'd5,  1'b1, 3'd4, 2'd0, 4'd4},   // R4 activate during precharge
    {8'd12, 4'd3, 2'd1, 12'h100, 4'd9,  1'b0, 3'd0, 2'd0, 4'd5},   // R5 read with auto-precharge
    {8'd13, 4'd3, 2'd1, 12'h000, 4'd3,  1'b1, 3'd5, 2'd1, 4'd5},   // R5 locked bank
    {8'd14, 4'd5, 2'd0, 12'h000, 4'd5,  1'b0, 3'd0, 2'd0, 4'd4},   // R4 activate at precharge limit
    {8'd15, 4'd7, 2'd0, 12'h000, 4'd7,  1'b1, 3'd3, 2'd0, 4'd6},   // R6 refresh with banks busy
    {8'd16, 4'd6, 2'd2, 12'h100, 4'd11, 1'b1, 3'd4, 2'd0, 4'd9},   // R9 precharge all, lowest bank
    {8'd17, 4'd4, 2'd0, 12'h100, 4'd10, 1'b1, 3'd4, 2'd0, 4'd4},   // R4 write before row delay
    {8'd18, 4'd5, 2'd1, 12'h000, 4'd5,  1'b0, 3'd0, 2'd0, 4'd5},   // R5 read lock ended exactly
    {8'd19, 4'd4, 2'd0, 12'h100, 4'd10, 1'b0, 3'd0, 2'd0, 4'd5},   // R5 write with auto-precharge
    {8'd20, 4'd3, 2'd1, 12'h000, 4'd3,  1'b1, 3'd4, 2'd1, 4'd4},   // R4 read before row delay
    {8'd21, 4'd6, 2'd0, 12'h000, 4'd6,  1'b1, 3'd5, 2'd0, 4'd5},   // R5 precharge of locked bank
    {8'd22, 4'd6, 2'd2, 12'h000, 4'd6,  1'b0, 3'd0, 2'd0, 4'd9},   // R9 precharge idle bank
    {8'd23, 4'd8, 2'd0, 12'h000, 4'd8,  1'b1, 3'd3, 2'd0, 4'd6},   // R6 mode load with banks busy
    {8'd25, 4'd5, 2'd1, 12'h000, 4'd5,  1'b1, 3'd2, 2'd1, 4'd3},   // R3 activate to open bank
    {8'd27, 4'd6, 2'd1, 12'h000, 4'd6,  1'b0, 3'd0, 2'd0, 4'd9},   // R9 single precharge
    {8'd28, 4'd3, 2'd0, 12'h000, 4'd3,  1'b1, 3'd1, 2'd0, 4'd5},   // R5 write lock ended, row closed
    {8'd31, 4'd7, 2'd0, 12'h000, 4'd7,  1'b0, 3'd0, 2'd0, 4'd6},   // R6 refresh all idle
    {8'd33, 4'd5, 2'd2, 12'h000, 4'd5,  1'b1, 3'd6, 2'd2, 4'd7},   // R7 refresh busy
    {8'd43, 4'd5, 2'd2, 12'h000, 4'd5,  1'b1, 3'd6, 2'd2, 4'd7},   // R7 last busy cycle
    {8'd44, 4'd8, 2'd0, 12'h003, 4'd8,  1'b0, 3'd0, 2'd0, 4'd10},  // R10 burst length 8
    {8'd45, 4'd5, 2'd3, 12'h000, 4'd5,  1'b1, 3'd6, 2'd3, 4'd7},   // R7 mode settle
    {8'd46, 4'd5, 2'd3, 12'h000, 4'd5,  1'b0, 3'd0, 2'd0, 4'd7},   // R7 settle over
    {8'd47, 4'd0, 2'd0, 12'h000, 4'd0,  1'b0, 3'd0, 2'd0, 4'd1},   // R1 deselect
    {8'd50, 4'd3, 2'd3, 12'h000, 4'd3,  1'b0, 3'd0, 2'd0, 4'd10},  // R10 read, long burst
    {8'd52, 4'd4, 2'd3, 12'h000, 4'd4,  1'b1, 3'd7, 2'd3, 4'd8},   // R8 write during read burst
    {8'd53, 4'd2, 2'd0, 12'h000, 4'd2,  1'b0, 3'd0, 2'd0, 4'd10},  // R10 stop legal in 8-burst
    {8'd54, 4'd2, 2'd0, 12'h000, 4'd2,  1'b1, 3'd7, 2'd0, 4'd8},   // R8 stop after stop
    {8'd55, 4'd3, 2'd3, 12'h100, 4'd9,  1'b0, 3'd0, 2'd0, 4'd10},  // R10 auto-precharge, BL8
    {8'd62, 4'd5, 2'd3, 12'h000, 4'd5,  1'b1, 3'd5, 2'd3, 4'd10},  // R10 window scales with BL
    {8'd63, 4'd5, 2'd3, 12'h000, 4'd5,  1'b0, 3'd0, 2'd0, 4'd10}   // R10 window end
  };

  task automatic drive(input logic [3:0] k, input logic [1:0] b, input logic [11:0] a);
    cs_n = (k == 4'd0);
    case (k)
      4'd2:    {ras_n, cas_n, we_n} = 3'b110;
      4'd3:    {ras_n, cas_n, we_n} = 3'b101;
      4'd4:    {ras_n, cas_n, we_n} = 3'b100;
      4'd5:    {ras_n, cas_n, we_n} = 3'b011;
      4'd6:    {ras_n, cas_n, we_n} = 3'b010;
      4'd7:    {ras_n, cas_n, we_n} = 3'b001;
      4'd8:    {ras_n, cas_n, we_n} = 3'b000;
      default: {ras_n, cas_n, we_n} = 3'b111;
    endcase
    ba   = b;
    addr = a;
  endtask

  task automatic expect_out(input logic [3:0] ec, input logic ei, input logic [2:0] er,
                            input logic [1:0] eb, input int rq, input int cyc);
    checks++;
    if (cmd_code !== ec || illegal !== ei || reason !== er || bad_bank !== eb) begin
      fails++;
      $display("FAIL R%0d cycle %0d: got code=%0d flag=%0b reason=%0d bank=%0d, expected code=%0d flag=%0b reason=%0d bank=%0d",
               rq, cyc, cmd_code, illegal, reason, bad_bank, ec, ei, er, eb);
    end
  endtask

  task automatic step(input logic [3:0] k, input logic [1:0] b, input logic [11:0] a,
                      input logic [3:0] ec, input logic ei, input logic [2:0] er,
                      input logic [1:0] eb, input int rq, input int cyc);
    drive(k, b, a);
    @(negedge clk);
    expect_out(ec, ei, er, eb, rq, cyc);
  endtask

  initial begin
    #(20 * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int idx;
    logic [39:0] e;
    rst_n = 1'b0;
    drive(4'd1, 2'd0, 12'h000);
    repeat (3) @(negedge clk);
    expect_out(4'd0, 1'b0, 3'd0, 2'd0, 12, -1);  // R12 reset outputs
    rst_n = 1'b1;

    idx = 0;
    for (int c = 0; c < 64; c++) begin
      if (idx < NT && int'(TBL[idx][39:32]) == c) begin
        e = TBL[idx];
        idx++;
        step(e[31:28], e[27:26], e[25:14], e[13:10], e[9], e[8:6], e[5:4], int'(e[3:0]), c);
      end else begin
        step(4'd1, 2'd0, 12'h000, 4'd1, 1'b0, 3'd0, 2'd0, 11, c);  // R11 quiet no-op
      end
    end

    // R12 reset in the middle of a run clears open rows
    rst_n = 1'b0;
    drive(4'd1, 2'd0, 12'h000);
    @(negedge clk);
    @(negedge clk);
    expect_out(4'd0, 1'b0, 3'd0, 2'd0, 12, 100);
    rst_n = 1'b1;
    step(4'd3, 2'd3, 12'h000, 4'd3, 1'b1, 3'd1, 2'd3, 12, 101);

    // R10 burst length 2: read burst lasts one cycle
    step(4'd8, 2'd0, 12'h001, 4'd8, 1'b0, 3'd0, 2'd0, 10, 102);
    step(4'd1, 2'd0, 12'h000, 4'd1, 1'b0, 3'd0, 2'd0, 7, 103);
    step(4'd5, 2'd0, 12'h000, 4'd5, 1'b0, 3'd0, 2'd0, 7, 104);
    step(4'd1, 2'd0, 12'h000, 4'd1, 1'b0, 3'd0, 2'd0, 11, 105);
    step(4'd1, 2'd0, 12'h000, 4'd1, 1'b0, 3'd0, 2'd0, 11, 106);
    step(4'd1, 2'd0, 12'h000, 4'd1, 1'b0, 3'd0, 2'd0, 11, 107);
    step(4'd3, 2'd0, 12'h000, 4'd3, 1'b0, 3'd0, 2'd0, 4, 108);
    step(4'd2, 2'd0, 12'h000, 4'd2, 1'b0, 3'd0, 2'd0, 10, 109);
    step(4'd2, 2'd0, 12'h000, 4'd2, 1'b1, 3'd7, 2'd0, 8, 110);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule